// File: doc/BRIEF.md
# Ethernet MAC interrupt event and mask unit

This block collects the interrupt causes of an Ethernet MAC in a sticky event register and gates them through a mask register. It drives thirteen separate interrupt lines, each tied to one masked event. The transmit, receive and management logic raise events with one-cycle set pulses. Software reads either register, clears events by writing ones, and loads the mask by a plain write.

Two events are raised as side effects of writes to other control registers. A write to the transmit control register with bit 0 set raises graceful stop at once. Any write to the management frame register raises the management event. A controller reset input clears both the event register and the mask register in one cycle.

Top module: `mac_irq_unit`

## Requirements
- R1: After rst_ni is released, the event register reads 0, the mask register reads 0 and all irq_o lines are 0.
- R2: A 1 on ev_set_i[k] in a cycle sets event bit 19+k from the next clock edge, and the bit stays set until it is cleared. The event bit positions are: heartbeat 31, babbling receive 30, babbling transmit 29, graceful stop 28, tx frame 27, tx buffer 26, rx frame 25, rx buffer 24, management 23, bus error 22, late collision 21, retry limit 20, underrun 19.
- R3: A write to address 0 (event) clears each event bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged.
- R4: When a set pulse and a clearing write hit the same event bit in the same cycle, the bit ends up set.
- R5: A write to address 1 (mask) stores all 32 data bits. Reading address 1 returns the mask and reading address 0 returns the event register, combinationally.
- R6: irq_o[i] equals (event AND mask) at bit src(i), one clock edge after the register update. src for lines 0 to 12 is 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30. A line changes only when its masked bit changes.
- R7: A write to address 2 (transmit control) with data bit 0 set raises event bit 28. With data bit 0 clear it leaves the events unchanged.
- R8: Any write to address 3 (management frame) raises event bit 23, whatever the data.
- R9: A 1 on ctl_rst_i clears the event and mask registers at the next edge, and this takes priority over any set in that cycle.
- R10: Event bits 18 to 0 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctl_rst_i | input | 1 | Synchronous controller reset, clears event and mask |
| ev_set_i | input | 13 | Set pulses; bit k raises event bit 19+k |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 event, 1 mask, 2 tx control, 3 management frame |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 2 | Read address: 0 event, 1 mask, others read 0 |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 13 | Registered interrupt lines |

## Verification
The assertions assume one register write per cycle, so a clearing write never coincides with a side-effect set from another address. They also assume that set pulses and the controller reset are held low while rst_ni is asserted. The bench drives every input on the falling edge and returns all strobes to zero before the next stimulus, which keeps it within both assumptions. The sweeps walk each event bit and each line separately. Collisions are created on purpose, one event bit at a time.

// File: rtl/mac_irq_pkg.sv
package mac_irq_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 2;
  localparam int EV_N    = 13;
  localparam int EV_LSB  = DATA_W - EV_N;
  localparam int LINE_N  = 13;

  localparam int BIT_GRA = 28;
  localparam int BIT_MII = 23;

  typedef enum logic [ADDR_W-1:0] {
    SEL_EVENT = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_TXCTL = 2'd2,
    SEL_MGMT  = 2'd3
  } reg_sel_e;

  // event bit that feeds each interrupt line
  function automatic int line_src(input int line);
    case (line)
      0:       return 27;
      1:       return 26;
      2:       return 19;
      3:       return 20;
      4:       return 25;
      5:       return 24;
      6:       return 23;
      7:       return 21;
      8:       return 31;
      9:       return 28;
      10:      return 22;
      11:      return 29;
      default: return 30;
    endcase
  endfunction
endpackage

// File: rtl/irq_event_reg.sv
module irq_event_reg #(
  parameter int EV_N = 13
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_all_i,
  input  logic [EV_N-1:0] set_i,
  input  logic            w1c_en_i,
  input  logic [EV_N-1:0] w1c_data_i,
  output logic [EV_N-1:0] ev_o
);
  logic [EV_N-1:0] ev_q, ev_d, clr_mask;

  always_comb begin
    clr_mask = w1c_en_i ? w1c_data_i : '0;
    // set beats clear; controller reset beats both
    ev_d = (ev_q & ~clr_mask) | set_i;
    if (clr_all_i) ev_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= ev_d;
  end

  assign ev_o = ev_q;
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] mask_o
);
  logic [DATA_W-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mask_q <= '0;
    else if (clr_all_i) mask_q <= '0;
    else if (we_i)      mask_q <= wdata_i;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_line_map.sv
module irq_line_map
  import mac_irq_pkg::*;
#(
  parameter int EV_N   = 13,
  parameter int LSB    = 19,
  parameter int LINE_N = 13
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [EV_N-1:0]   active_i,
  output logic [LINE_N-1:0] irq_o
);
  logic [LINE_N-1:0] irq_q;

  for (genvar g = 0; g < LINE_N; g++) begin : g_line
    localparam int SRC = line_src(g) - LSB;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q[g] <= 1'b0;
      else         irq_q[g] <= active_i[SRC];
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/mac_irq_unit.sv
module mac_irq_unit
  import mac_irq_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int NEV = EV_N,
  parameter int NLN = LINE_N
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           ctl_rst_i,
  input  logic [NEV-1:0] ev_set_i,
  input  logic           wr_en_i,
  input  logic [AW-1:0]  wr_addr_i,
  input  logic [DW-1:0]  wr_data_i,
  input  logic [AW-1:0]  rd_addr_i,
  output logic [DW-1:0]  rd_data_o,
  output logic [NLN-1:0] irq_o
);
  localparam int LSB = DW - NEV;

  logic           wr_ev, wr_mask, wr_tx, wr_mgmt;
  logic [NEV-1:0] side_set, set_all, ev_bits, act_bits;
  logic [DW-1:0]  ev_w, mask_w;

  always_comb begin
    wr_ev   = wr_en_i && (wr_addr_i == SEL_EVENT);
    wr_mask = wr_en_i && (wr_addr_i == SEL_MASK);
    wr_tx   = wr_en_i && (wr_addr_i == SEL_TXCTL);
    wr_mgmt = wr_en_i && (wr_addr_i == SEL_MGMT);
    side_set = '0;
    side_set[BIT_GRA-LSB] = wr_tx && wr_data_i[0];
    side_set[BIT_MII-LSB] = wr_mgmt;
    set_all = ev_set_i | side_set;
  end

  irq_event_reg #(.EV_N(NEV)) u_ev (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_all_i  (ctl_rst_i),
    .set_i      (set_all),
    .w1c_en_i   (wr_ev),
    .w1c_data_i (wr_data_i[DW-1:LSB]),
    .ev_o       (ev_bits)
  );

  irq_mask_reg #(.DATA_W(DW)) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (ctl_rst_i),
    .we_i      (wr_mask),
    .wdata_i   (wr_data_i),
    .mask_o    (mask_w)
  );

  assign ev_w     = {ev_bits, {LSB{1'b0}}};
  assign act_bits = ev_bits & mask_w[DW-1:LSB];

  irq_line_map #(.EV_N(NEV), .LSB(LSB), .LINE_N(NLN)) u_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .active_i (act_bits),
    .irq_o    (irq_o)
  );

  always_comb begin
    case (rd_addr_i)
      SEL_EVENT: rd_data_o = ev_w;
      SEL_MASK:  rd_data_o = mask_w;
      default:   rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/mac_irq_unit_chk.sv
module mac_irq_unit_chk
  import mac_irq_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ctl_rst_i,
  input logic [EV_N-1:0]      ev_set_i,
  input logic                 wr_en_i,
  input logic [ADDR_W-1:0]    wr_addr_i,
  input logic [DATA_W-1:0]    wr_data_i,
  input logic [DATA_W-1:0]    ev_q,
  input logic [DATA_W-1:0]    mask_q,
  input logic [LINE_N-1:0]    irq_o
);
  logic [DATA_W-1:0] set_vec, act;
  logic [LINE_N-1:0] exp_lines;

  always_comb begin
    set_vec = DATA_W'(ev_set_i) << EV_LSB;
    act = ev_q & mask_q;
    for (int i = 0; i < LINE_N; i++) exp_lines[i] = act[line_src(i)];
  end

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_rst_i |=> ((ev_q & $past(set_vec)) == $past(set_vec))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_EVENT) |=>
      ((ev_q & $past(wr_data_i & ~set_vec)) == '0)); // R3

  AST_EV_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && ev_set_i == '0 && !ctl_rst_i) |=> $stable(ev_q)); // R3

  AST_LINE_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(exp_lines))); // R6

  AST_GRA_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_TXCTL && wr_data_i[0] && !ctl_rst_i)
      |=> ev_q[BIT_GRA]); // R7

  AST_MII_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == SEL_MGMT && !ctl_rst_i) |=> ev_q[BIT_MII]); // R8

  AST_CTL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rst_i |=> (ev_q == '0 && mask_q == '0)); // R9

  AST_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_q[EV_LSB-1:0] == '0); // R10
endmodule

bind mac_irq_unit mac_irq_unit_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ctl_rst_i (ctl_rst_i),
  .ev_set_i  (ev_set_i),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .ev_q      (ev_w),
  .mask_q    (mask_w),
  .irq_o     (irq_o)
);

// File: tb/mac_irq_unit_tb.sv
module mac_irq_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ctl_rst_i = 1'b0;
  logic [12:0] ev_set_i = '0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [1:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic [12:0] irq_o;

  int n_chk = 0;
  int n_bad = 0;
  int src [13] = '{27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29, 30};

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  mac_irq_unit u_dut (
    .clk_i, .rst_ni, .ctl_rst_i, .ev_set_i, .wr_en_i, .wr_addr_i,
    .wr_data_i, .rd_addr_i, .rd_data_o, .irq_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one stimulus cycle, then strobes return low; registers updated on return
  task automatic step(input logic [12:0] set, input logic we, input logic [1:0] a,
                      input logic [31:0] d, input logic crst);
    ev_set_i = set; wr_en_i = we; wr_addr_i = a; wr_data_i = d; ctl_rst_i = crst;
    @(negedge clk_i);
    ev_set_i = '0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; ctl_rst_i = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [31:0] exp);
    rd_addr_i = a;
    #1;
    chk(req, rd_data_o, exp);
  endtask

  function automatic logic [12:0] lines_of(input logic [31:0] act);
    logic [12:0] l;
    for (int i = 0; i < 13; i++) l[i] = act[src[i]];
    return l;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] exp_ev;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    rd_chk("R1 event", 2'd0, '0);
    rd_chk("R1 mask", 2'd1, '0);
    chk("R1 irq", {19'd0, irq_o}, '0);

    step('0, 1'b1, 2'd1, 32'hA5A5_5A5A, 1'b0);
    rd_chk("R5 mask pattern", 2'd1, 32'hA5A5_5A5A);
    step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0);
    rd_chk("R5 mask ones", 2'd1, 32'hFFFF_FFFF);
    rd_chk("R5 unused addr", 2'd2, '0);

    // R2 R3 R6: walk each event bit
    for (int k = 0; k < 13; k++) begin
      step(13'(1) << k, 1'b0, 2'd0, '0, 1'b0);
      exp_ev = 32'(1) << (19 + k);
      rd_chk("R2 set", 2'd0, exp_ev);
      @(negedge clk_i);
      rd_chk("R2 sticky", 2'd0, exp_ev);
      chk("R6 line", {19'd0, irq_o}, {19'd0, lines_of(exp_ev)});
      step('0, 1'b1, 2'd0, exp_ev, 1'b0);
      rd_chk("R3 clear", 2'd0, '0);
      @(negedge clk_i);
      chk("R6 line drop", {19'd0, irq_o}, '0);
    end

    // R6 R10: all events set, one mask bit at a time
    step(13'h1FFF, 1'b0, 2'd0, '0, 1'b0);
    rd_chk("R10 low bits", 2'd0, 32'hFFF8_0000);
    for (int i = 0; i < 13; i++) begin
      step('0, 1'b1, 2'd1, 32'(1) << src[i], 1'b0);
      @(negedge clk_i);
      chk("R6 mask sweep", {19'd0, irq_o}, 32'(1) << i);
    end
    step('0, 1'b1, 2'd1, '0, 1'b0);
    @(negedge clk_i);
    chk("R6 masked off", {19'd0, irq_o}, '0);

    // R3 partial clear
    step('0, 1'b1, 2'd0, 32'h5555_5555, 1'b0);
    rd_chk("R3 partial", 2'd0, 32'hFFF8_0000 & ~32'h5555_5555);
    step('0, 1'b1, 2'd0, 32'h0000_0000, 1'b0);
    rd_chk("R3 zero write", 2'd0, 32'hFFF8_0000 & ~32'h5555_5555);

    // R4 collisions
    for (int k = 0; k < 13; k++) begin
      step(13'h1FFF, 1'b0, 2'd0, '0, 1'b0);
      step(13'(1) << k, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
      rd_chk("R4 set wins", 2'd0, 32'(1) << (19 + k));
    end
    step('0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);

    // R7 R8 side-effect events
    step('0, 1'b1, 2'd2, 32'hFFFF_FFFE, 1'b0);
    rd_chk("R7 bit0 clear", 2'd0, '0);
    step('0, 1'b1, 2'd2, 32'h0000_0001, 1'b0);
    rd_chk("R7 graceful", 2'd0, 32'h1000_0000);
    step('0, 1'b1, 2'd0, 32'hFFFF_FFFF, 1'b0);
    step('0, 1'b1, 2'd3, 32'h0000_0000, 1'b0);
    rd_chk("R8 mgmt", 2'd0, 32'h0080_0000);

    // R9 controller reset beats a set
    step('0, 1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0);
    step(13'h1FFF, 1'b0, 2'd0, '0, 1'b0);
    @(negedge clk_i);
    chk("R6 all lines", {19'd0, irq_o}, 32'h1FFF);
    step(13'h1FFF, 1'b0, 2'd0, '0, 1'b1);
    rd_chk("R9 event", 2'd0, '0);
    rd_chk("R9 mask", 2'd1, '0);
    @(negedge clk_i);
    chk("R9 irq", {19'd0, irq_o}, '0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule